// File: doc/BRIEF.md
# Majority-Cell Chain Self-Test Controller

The block holds a one-dimensional chain of identical three-input, three-output cells. Each cell computes three majority votes. Every cell takes its first two inputs from the previous cell's first two outputs. The chain head takes them from two primary inputs. The third input of every cell is driven separately from outside the chain, and the third output of every cell is observed. The last cell's first two outputs are the primary outputs of the chain.

A built-in sequencer runs a three-vector test that does not depend on the chain length. A checker compares every observed output with a fault-free copy of the chain, which runs alongside it. The checker keeps a sticky pass/fail verdict, a per-cell mismatch mask and a separate flag for the chain-end pair.

Each output pin of each cell has an inversion control. Any combination of cells can be made faulty, so detection of multiple faults can be tried.

Top module: `maj_array_tester`

## Requirements
- R1: Cell i (0-based) computes out1 = MAJ(a,b,c), out2 = MAJ(a,b,~c), out3 = MAJ(~a,b,c). Its inputs are a and b, plus its own control input c. Cell 0 takes a and b from the stimulus pins p1 and p2. Every later cell takes a and b from out1 and out2 of the previous cell. The chain-end pair is {out1,out2} of the last cell.
- R2: A start pulse seen while idle begins a test. busy is high for the three cycles after the accepting edge. done is a one-cycle pulse in the cycle after the third vector, and busy falls in that same cycle.
- R3: The vectors are applied in this order. Vector 1 is p1=0, p2=0 with every c=1. Vector 2 is p1=1, p2=0 with every c=1. Vector 3 is p1=0, p2=1, with c=1 on cells of even index and c=0 on cells of odd index.
- R4: With no fault injected, a completed test reports fail=0, an all-zero mismatch mask and poMismatch=0.
- R5: Bit 3*i+k of faultInv inverts output k+1 of cell i, where k=0 is out1, k=1 is out2 and k=2 is out3. An inverted out1 or out2 feeds the next cell in its inverted form.
- R6: Bit i of y3Mismatch is set when out3 of cell i differs from its fault-free value in at least one of the three vectors.
- R7: poMismatch is set when the chain-end pair differs from its fault-free value in at least one vector. The fault-free pair is 00 for vector 1 and 10 for vector 2. For vector 3 it is 01 when the cell count is even and 10 when it is odd.
- R8: fail is the OR of every mismatch seen. fail, y3Mismatch and poMismatch stay set while the chain is idle and are cleared only by an accepted start.
- R9: A start pulse while busy is ignored. The running test keeps its timing and produces exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test when idle |
| faultInv | input | 3*NUM_CELLS | Per-cell, per-output inversion controls |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Sticky overall mismatch flag |
| y3Mismatch | output | NUM_CELLS | Per-cell out3 mismatch mask |
| poMismatch | output | 1 | Chain-end pair mismatch flag |

## Verification
The start pulse is taken on edge 0. The three vectors are held over the three following cycles, and the checker folds in each vector's comparison on the edge that ends its cycle. done, the cleared busy and the final verdict therefore all appear just after the third edge following the accepting edge. The bench drives inputs on falling edges. It samples busy one half-cycle after acceptance and samples the results one half-cycle after the third edge. It checks that done has fallen one cycle later. Expected masks come from the bench's own model of the chain under the applied inversions.

// File: rtl/maj_tester_pkg.sv
package maj_tester_pkg;
  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic       clear;   // wipe the accumulated verdict
    logic       apply;   // a vector is on the chain this cycle
    logic [1:0] vecSel;  // 1..3 selects the vector, 0 when idle
  } strobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_V1   = 2'd1,
    ST_V2   = 2'd2,
    ST_V3   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/maj_cell.sv
module maj_cell (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic out1,
  output logic out2,
  output logic out3
);
  function automatic logic maj3(input logic p, input logic q, input logic r);
    return (p & q) | (p & r) | (q & r);
  endfunction

  always_comb begin
    out1 = maj3(a, b, c);
    out2 = maj3(a, b, ~c);
    out3 = maj3(~a, b, c);
  end
endmodule

// File: rtl/maj_chain.sv
module maj_chain #(
  parameter int NUM_CELLS = 6
) (
  input  logic                   p1,
  input  logic                   p2,
  input  logic [NUM_CELLS-1:0]   ctl,
  input  logic [3*NUM_CELLS-1:0] inv,
  output logic [NUM_CELLS-1:0]   obs,
  output logic [1:0]             tail
);
  logic [NUM_CELLS:0] linkA;
  logic [NUM_CELLS:0] linkB;

  assign linkA[0] = p1;
  assign linkB[0] = p2;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    logic raw1, raw2, raw3;
    maj_cell u_cell (
      .a   (linkA[i]),
      .b   (linkB[i]),
      .c   (ctl[i]),
      .out1(raw1),
      .out2(raw2),
      .out3(raw3)
    );
    assign linkA[i+1] = raw1 ^ inv[3*i];
    assign linkB[i+1] = raw2 ^ inv[3*i+1];
    assign obs[i]     = raw3 ^ inv[3*i+2];
  end

  assign tail = {linkA[NUM_CELLS], linkB[NUM_CELLS]};
endmodule

// File: rtl/maj_test_ctrl.sv
module maj_test_ctrl
  import maj_tester_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output strobes_t strobes,
  output logic     busy,
  output logic     done
);
  seq_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = ST_V1;
      ST_V1:   stateNext = ST_V2;
      ST_V2:   stateNext = ST_V3;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_V3);
    end
  end

  always_comb begin
    strobes.clear  = (state == ST_IDLE) && start;
    strobes.apply  = (state != ST_IDLE);
    strobes.vecSel = state;
  end

  assign busy = (state != ST_IDLE);

  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_V2 && start) |=> (state == ST_V3));
endmodule

// File: rtl/maj_test_datapath.sv
module maj_test_datapath
  import maj_tester_pkg::*;
#(
  parameter int NUM_CELLS = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               strobes,
  input  logic [3*NUM_CELLS-1:0] faultInv,
  output logic                   fail,
  output logic [NUM_CELLS-1:0]   y3Mismatch,
  output logic                   poMismatch
);
  localparam int INV_W = 3 * NUM_CELLS;

  logic                 stimP1, stimP2;
  logic [NUM_CELLS-1:0] stimCtl;
  logic [NUM_CELLS-1:0] dutObs, refObs;
  logic [1:0]           dutTail, refTail;
  logic [NUM_CELLS-1:0] maskQ;
  logic                 poQ, failQ;
  logic [NUM_CELLS-1:0] obsDiff;
  logic                 tailDiff;

  always_comb begin
    case (strobes.vecSel)
      2'd2:    {stimP1, stimP2} = 2'b10;
      2'd3:    {stimP1, stimP2} = 2'b01;
      default: {stimP1, stimP2} = 2'b00;
    endcase
    for (int i = 0; i < NUM_CELLS; i++) begin
      stimCtl[i] = (strobes.vecSel == 2'd3) ? ((i % 2) == 0) : 1'b1;
    end
  end

  maj_chain #(.NUM_CELLS(NUM_CELLS)) u_dutChain (
    .p1(stimP1), .p2(stimP2), .ctl(stimCtl), .inv(faultInv),
    .obs(dutObs), .tail(dutTail)
  );

  maj_chain #(.NUM_CELLS(NUM_CELLS)) u_refChain (
    .p1(stimP1), .p2(stimP2), .ctl(stimCtl), .inv({INV_W{1'b0}}),
    .obs(refObs), .tail(refTail)
  );

  assign obsDiff  = dutObs ^ refObs;
  assign tailDiff = (dutTail != refTail);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      maskQ <= '0;
      poQ   <= 1'b0;
      failQ <= 1'b0;
    end else if (strobes.apply) begin
      maskQ <= maskQ | obsDiff;
      poQ   <= poQ | tailDiff;
      failQ <= failQ | tailDiff | (|obsDiff);
    end
  end

  assign fail       = failQ;
  assign y3Mismatch = maskQ;
  assign poMismatch = poQ;

  p_ref_v1_obs_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.apply && strobes.vecSel == 2'd1) |-> (refObs == {NUM_CELLS{1'b1}} && refTail == 2'b00));
  p_ref_v2_obs_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.apply && strobes.vecSel == 2'd2) |-> (refObs == '0 && refTail == 2'b10));
  p_ref_v3_tail_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.apply && strobes.vecSel == 2'd3) |->
      (refTail == (((NUM_CELLS % 2) == 0) ? 2'b01 : 2'b10)));
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (failQ && !strobes.clear) |=> failQ);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (!failQ && maskQ == '0 && !poQ));
endmodule

// File: rtl/maj_array_tester.sv
module maj_array_tester
  import maj_tester_pkg::*;
#(
  parameter int NUM_CELLS = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [3*NUM_CELLS-1:0] faultInv,
  output logic                   busy,
  output logic                   done,
  output logic                   fail,
  output logic [NUM_CELLS-1:0]   y3Mismatch,
  output logic                   poMismatch
);
  strobes_t strobes;

  maj_test_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobes(strobes), .busy(busy), .done(done)
  );

  maj_test_datapath #(.NUM_CELLS(NUM_CELLS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .faultInv(faultInv),
    .fail(fail), .y3Mismatch(y3Mismatch), .poMismatch(poMismatch)
  );
endmodule

// File: tb/maj_array_tester_tb.sv
module maj_array_tester_tb;
  localparam int NC = 5;
  localparam int FW = 3 * NC;
  localparam int NPAT = 7;
  // Faults to inject; the expected verdict for each comes from chainModel.
  localparam logic [FW-1:0] PATS [NPAT] = '{
    15'h0000,  // fault free (R4)
    15'h0100,  // cell 2 out3 inverted (R6)
    15'h0001,  // cell 0 out1 inverted, propagates (R5)
    15'h2000,  // cell 4 out2 inverted, tail only (R7)
    15'h0121,  // several cells faulty
    15'h0018,  // cell 1 out1 and out2 inverted
    15'h7FFF   // everything inverted
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [FW-1:0] faultInv = '0;
  logic busy, done, fail, poMismatch;
  logic [NC-1:0] y3Mismatch;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  maj_array_tester #(.NUM_CELLS(NC)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .faultInv(faultInv),
    .busy(busy), .done(done), .fail(fail),
    .y3Mismatch(y3Mismatch), .poMismatch(poMismatch)
  );

  function automatic logic mj(input logic p, input logic q, input logic r);
    return (p & q) | (p & r) | (q & r);
  endfunction

  // Returns {poMismatch, y3Mismatch} expected for fault set f (R1, R3, R5).
  function automatic logic [NC:0] chainModel(input logic [FW-1:0] f);
    logic [NC-1:0] m;
    logic po;
    m = '0;
    po = 1'b0;
    for (int v = 1; v <= 3; v++) begin
      logic ca, cb, fa, fb, c, ga, gb, na, nb, g3, n3;
      ca = (v == 2); cb = (v == 3);
      fa = ca; fb = cb;
      for (int i = 0; i < NC; i++) begin
        c = (v == 3) ? ((i % 2) == 0) : 1'b1;
        ga = mj(ca, cb, c); gb = mj(ca, cb, ~c); g3 = mj(~ca, cb, c);
        na = mj(fa, fb, c) ^ f[3*i];
        nb = mj(fa, fb, ~c) ^ f[3*i+1];
        n3 = mj(~fa, fb, c) ^ f[3*i+2];
        if (g3 != n3) m[i] = 1'b1;
        ca = ga; cb = gb; fa = na; fb = nb;
      end
      if ({ca, cb} != {fa, fb}) po = 1'b1;
    end
    return {po, m};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Start on a falling edge; results are sampled half a cycle after the third edge.
  task automatic runTest(input logic [FW-1:0] f, input bit pokeWhileBusy);
    logic [NC:0] e;
    e = chainModel(f);
    faultInv = f;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy === 1'b1, "R2 busy after accept", busy, 1);
    @(negedge clk);
    if (pokeWhileBusy) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(done === 1'b0 && busy === 1'b1, "R2/R9 mid-test", {busy, done}, 2);
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R2 done pulse", {busy, done}, 1);
    check(y3Mismatch === e[NC-1:0], "R6 out3 mask", y3Mismatch, e[NC-1:0]);
    check(poMismatch === e[NC], "R7 tail flag", poMismatch, e[NC]);
    check(fail === (|e), "R8 fail", fail, |e);
    @(negedge clk);
    check(done === 1'b0, "R2 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(busy === 1'b0 && done === 1'b0 && fail === 1'b0 &&
          y3Mismatch === '0 && poMismatch === 1'b0, "reset state",
          {busy, done, fail, poMismatch}, 0);

    for (int k = 0; k < NPAT; k++) runTest(PATS[k], 1'b0);

    // R4: fault-free run after a failing one clears everything.
    runTest('0, 1'b0);
    check(fail === 1'b0 && y3Mismatch === '0, "R4 fault free clean", fail, 0);

    // R5: the hand-derived mask for a lone cell-2 out3 inversion.
    runTest(15'h0100, 1'b0);
    check(y3Mismatch === 5'b00100 && poMismatch === 1'b0, "R5 single out3", y3Mismatch, 4);

    // R8: the verdict holds while idle, even after the fault is removed.
    faultInv = '0;
    repeat (5) @(negedge clk);
    check(fail === 1'b1 && y3Mismatch === 5'b00100, "R8 sticky", fail, 1);

    // R9: a start pulse while busy neither restarts nor doubles done.
    runTest(15'h0001, 1'b1);
    repeat (4) begin
      @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R9 no second run", {busy, done}, 0);
    end

    // R1/R3: an odd-length chain gives the tail 10 in vector 3; an out1 fault in the last cell shows only there.
    runTest(15'h1000, 1'b0);
    check(poMismatch === 1'b1 && y3Mismatch === '0, "R1 tail only", poMismatch, 1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule